// File: doc/BRIEF.md
# Flash Command Scheduler with Read Bypass

This block sits between the translation firmware and a set of independent flash bus controllers. It takes page read, page program and block erase commands from one stream input and holds them in a small ordered queue. It hands each command to the controller of the bus it addresses. Every chip has a lock, so a chip never has two operations at once. A read may move ahead of older queued programs and erases when it does not touch the data they change.

The command input is a valid/ready stream. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` depends only on the queue occupancy and drops while all eight slots are used. Each bus has its own issue stream, and a command leaves on an edge where `iss_valid` and `iss_ready` of its bus are both high. While `iss_ready` is low, the command offered on a bus can be replaced by one of higher priority, for example a newly arrived read.

Each chip has one completion pulse input. A pulse sets that chip to the "finished" state. The tag of the finished operation is then returned on the completion stream, which holds its tag stable until `cpl_ready` accepts it. The chip lock is freed on the edge where that completion is accepted.

Top module: `flash_cmd_sched`

## Requirements
- R1: After reset, `cmd_ready` is 1, every `iss_valid` bit is 0 and `cpl_valid` is 0.
- R2: No command is offered to a chip while an earlier operation on that chip is issued but its completion has not been accepted.
- R3: Opcodes are 0 for read, 1 for program and 2 for erase. On each bus, the oldest eligible read is offered before any program or erase. Such a read may pass older programs and erases to the same chip when no dependency exists.
- R4: A read is held back when an older queued program targets the same bus, chip, block and page (opcode 1), or when an older queued erase targets the same bus, chip and block (opcode 2).
- R5: A program or erase is never offered while an older queued command of any type targets the same chip.
- R6: When no read is eligible on a bus, that bus offers its oldest eligible program or erase. The fields offered are those of the queued command, and an accepted command is removed from the queue.
- R7: A completion pulse on input bit `bus*16+chip` of a chip with an operation in flight makes the completion port return the tag of that operation. After the completion is accepted, the chip can be issued again on the following cycle.
- R8: With 8 commands queued, `cmd_ready` is 0, and a command presented with `cmd_valid` is not taken.
- R9: The buses are independent, and every bus can issue a command on the same clock edge.
- R10: While `cpl_valid` is high and `cpl_ready` is low, `cpl_valid` stays high and `cpl_tag` does not change. When no completion is being held, the finished chip with the lowest index `bus*16+chip` is reported first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready, low while the queue is full |
| cmd_op | input | 2 | Opcode: 0 read, 1 program, 2 erase |
| cmd_bus | input | 2 | Target bus |
| cmd_chip | input | 4 | Target chip on that bus |
| cmd_block | input | 10 | Target block |
| cmd_page | input | 6 | Target page (unused for erase) |
| cmd_tag | input | 4 | Tag returned on completion |
| iss_valid | output | 4 | Per-bus issue valid |
| iss_ready | input | 4 | Per-bus issue ready from the bus controller |
| iss_op | output | 4x2 | Per-bus opcode |
| iss_chip | output | 4x4 | Per-bus chip |
| iss_block | output | 4x10 | Per-bus block |
| iss_page | output | 4x6 | Per-bus page |
| iss_tag | output | 4x4 | Per-bus tag |
| done_pulse | input | 64 | One-cycle completion pulse per chip, bit `bus*16+chip` |
| cpl_valid | output | 1 | Completion stream valid |
| cpl_ready | input | 1 | Completion stream ready |
| cpl_tag | output | 4 | Tag of the finished operation |

## Verification
The assertions assume two things about the inputs. A completion pulse arrives only for a chip whose operation has been issued and whose completion is not yet pending. The opcode value 3 is never presented. The stimulus meets both: it pulses only chips that its own reference model shows as in flight, and it draws opcodes from 0 to 2. Addresses are confined to a few chips, blocks and pages so that locks, dependencies and same-chip ordering collide often. Ready on the issue and completion streams is dropped at random to exercise replacement on the issue ports and holding on the completion port.

// File: rtl/flash_sched_pkg.sv
package flash_sched_pkg;
  parameter int NUM_BUS       = 4;
  parameter int CHIPS_PER_BUS = 16;
  parameter int BLOCK_W       = 10;
  parameter int PAGE_W        = 6;
  parameter int TAG_W         = 4;
  parameter int QDEPTH        = 8;

  localparam int BUS_W  = $clog2(NUM_BUS);
  localparam int CHIP_W = $clog2(CHIPS_PER_BUS);
  localparam int NCHIP  = NUM_BUS * CHIPS_PER_BUS;
  localparam int CID_W  = BUS_W + CHIP_W;
  localparam int QIDX_W = $clog2(QDEPTH);
  localparam int QCNT_W = $clog2(QDEPTH + 1);

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_BUSY = 2'd1,
    CS_DONE = 2'd2
  } chip_st_e;

  typedef struct packed {
    op_e                op;
    logic [BUS_W-1:0]   bus;
    logic [CHIP_W-1:0]  chip;
    logic [BLOCK_W-1:0] block;
    logic [PAGE_W-1:0]  page;
    logic [TAG_W-1:0]   tag;
  } cmd_t;
endpackage

// File: rtl/flash_cmd_queue.sv
// Age-ordered command store: slot 0 is the oldest. Any set of slots may
// leave in one cycle; survivors close up and a new command is appended.
module flash_cmd_queue
  import flash_sched_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  cmd_t                in_cmd,
  output logic                in_ready,
  input  logic [QDEPTH-1:0]   rm_mask,
  output cmd_t [QDEPTH-1:0]   slots,
  output logic [QDEPTH-1:0]   slot_vld
);
  logic [QCNT_W-1:0] count_q, count_d;
  cmd_t [QDEPTH-1:0] slots_q, slots_d;

  assign in_ready = (count_q < QCNT_W'(QDEPTH));
  assign slots    = slots_q;

  for (genvar i = 0; i < QDEPTH; i++) begin : g_vld
    assign slot_vld[i] = (QCNT_W'(i) < count_q);
  end

  always_comb begin
    int w;
    w       = 0;
    slots_d = slots_q;
    for (int i = 0; i < QDEPTH; i++) begin
      if (slot_vld[i] && !rm_mask[i]) begin
        slots_d[w[QIDX_W-1:0]] = slots_q[i];
        w = w + 1;
      end
    end
    if (in_valid && in_ready && (w < QDEPTH)) begin
      slots_d[w[QIDX_W-1:0]] = in_cmd;
      w = w + 1;
    end
    count_d = QCNT_W'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      slots_q <= '0;
    end else begin
      count_q <= count_d;
      slots_q <= slots_d;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= QCNT_W'(QDEPTH));

  assert_rm_only_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_mask & ~slot_vld) == '0);
endmodule

// File: rtl/flash_dispatch_pick.sv
// Eligibility (locks, read dependencies, same-chip order) and per-bus choice.
module flash_dispatch_pick
  import flash_sched_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  cmd_t [QDEPTH-1:0]              slots,
  input  logic [QDEPTH-1:0]              slot_vld,
  input  logic [NCHIP-1:0]               chip_free,
  input  logic [NUM_BUS-1:0]             iss_ready,
  output logic [NUM_BUS-1:0]             iss_valid,
  output logic [NUM_BUS-1:0][QIDX_W-1:0] iss_idx,
  output logic [QDEPTH-1:0]              rm_mask,
  output logic [NCHIP-1:0]               chip_take
);
  logic [QDEPTH-1:0] elig;
  logic [QDEPTH-1:0] held;

  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      held[i] = 1'b0;
      for (int k = 0; k < QDEPTH; k++) begin
        if ((k < i) && slot_vld[k] &&
            (slots[k].bus == slots[i].bus) && (slots[k].chip == slots[i].chip)) begin
          if (slots[i].op == OP_READ) begin
            if ((slots[k].op != OP_READ) && (slots[k].block == slots[i].block) &&
                ((slots[k].op == OP_ERASE) || (slots[k].page == slots[i].page)))
              held[i] = 1'b1;
          end else begin
            held[i] = 1'b1;
          end
        end
      end
      elig[i] = slot_vld[i] && !held[i] && chip_free[{slots[i].bus, slots[i].chip}];
    end
  end

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic              has_rd, has_wr;
    logic [QIDX_W-1:0] idx_rd, idx_wr;

    always_comb begin
      has_rd = 1'b0;
      has_wr = 1'b0;
      idx_rd = '0;
      idx_wr = '0;
      for (int i = QDEPTH - 1; i >= 0; i--) begin
        if (elig[i] && (slots[i].bus == BUS_W'(b))) begin
          if (slots[i].op == OP_READ) begin
            has_rd = 1'b1;
            idx_rd = QIDX_W'(i);
          end else begin
            has_wr = 1'b1;
            idx_wr = QIDX_W'(i);
          end
        end
      end
    end

    assign iss_valid[b] = has_rd | has_wr;
    assign iss_idx[b]   = has_rd ? idx_rd : idx_wr;

    assert_pick_on_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[b] |-> (slot_vld[iss_idx[b]] && (slots[iss_idx[b]].bus == BUS_W'(b))));
  end

  always_comb begin
    rm_mask   = '0;
    chip_take = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (iss_valid[b] && iss_ready[b]) begin
        rm_mask[iss_idx[b]] = 1'b1;
        chip_take[{slots[iss_idx[b]].bus, slots[iss_idx[b]].chip}] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_chip_locks.sv
// Per-chip lock state and the completion stream.
module flash_chip_locks
  import flash_sched_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCHIP-1:0]              chip_take,
  input  logic [NUM_BUS-1:0][TAG_W-1:0] bus_tag,
  input  logic [NCHIP-1:0]              done_pulse,
  input  logic                          cpl_ready,
  output logic [NCHIP-1:0]              chip_free,
  output logic                          cpl_valid,
  output logic [TAG_W-1:0]              cpl_tag
);
  logic [NCHIP-1:0]            done_vec;
  logic [NCHIP-1:0][TAG_W-1:0] tag_vec;
  logic                        hold_q;
  logic [CID_W-1:0]            hold_idx_q, sel;
  logic                        cpl_fire;

  always_comb begin
    sel = hold_idx_q;
    if (!hold_q) begin
      sel = '0;
      for (int c = NCHIP - 1; c >= 0; c--)
        if (done_vec[c]) sel = CID_W'(c);
    end
  end

  assign cpl_valid = |done_vec;
  assign cpl_tag   = tag_vec[sel];
  assign cpl_fire  = cpl_valid && cpl_ready;

  for (genvar c = 0; c < NCHIP; c++) begin : g_chip
    localparam int BUS_OF = c / CHIPS_PER_BUS;
    chip_st_e         st_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q  <= CS_IDLE;
        tag_q <= '0;
      end else begin
        case (st_q)
          CS_IDLE: if (chip_take[c]) begin
            st_q  <= CS_BUSY;
            tag_q <= bus_tag[BUS_OF];
          end
          CS_BUSY: if (done_pulse[c]) st_q <= CS_DONE;
          CS_DONE: if (cpl_fire && (sel == CID_W'(c))) st_q <= CS_IDLE;
          default: st_q <= CS_IDLE;
        endcase
      end
    end

    assign chip_free[c] = (st_q == CS_IDLE);
    assign done_vec[c]  = (st_q == CS_DONE);
    assign tag_vec[c]   = tag_q;

    assert_take_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      chip_take[c] |-> (st_q == CS_IDLE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= cpl_valid && !cpl_ready;
      hold_idx_q <= sel;
    end
  end

  assert_cpl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_tag)));
endmodule

// File: rtl/flash_cmd_sched.sv
module flash_cmd_sched
  import flash_sched_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_valid,
  output logic                            cmd_ready,
  input  logic [1:0]                      cmd_op,
  input  logic [BUS_W-1:0]                cmd_bus,
  input  logic [CHIP_W-1:0]               cmd_chip,
  input  logic [BLOCK_W-1:0]              cmd_block,
  input  logic [PAGE_W-1:0]               cmd_page,
  input  logic [TAG_W-1:0]                cmd_tag,
  output logic [NUM_BUS-1:0]              iss_valid,
  input  logic [NUM_BUS-1:0]              iss_ready,
  output logic [NUM_BUS-1:0][1:0]         iss_op,
  output logic [NUM_BUS-1:0][CHIP_W-1:0]  iss_chip,
  output logic [NUM_BUS-1:0][BLOCK_W-1:0] iss_block,
  output logic [NUM_BUS-1:0][PAGE_W-1:0]  iss_page,
  output logic [NUM_BUS-1:0][TAG_W-1:0]   iss_tag,
  input  logic [NCHIP-1:0]                done_pulse,
  output logic                            cpl_valid,
  input  logic                            cpl_ready,
  output logic [TAG_W-1:0]                cpl_tag
);
  cmd_t                           in_cmd;
  cmd_t [QDEPTH-1:0]              slots;
  logic [QDEPTH-1:0]              slot_vld;
  logic [QDEPTH-1:0]              rm_mask;
  logic [NCHIP-1:0]               chip_free;
  logic [NCHIP-1:0]               chip_take;
  logic [NUM_BUS-1:0][QIDX_W-1:0] iss_idx;

  always_comb begin
    in_cmd.op    = op_e'(cmd_op);
    in_cmd.bus   = cmd_bus;
    in_cmd.chip  = cmd_chip;
    in_cmd.block = cmd_block;
    in_cmd.page  = cmd_page;
    in_cmd.tag   = cmd_tag;
  end

  flash_cmd_queue u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (cmd_valid),
    .in_cmd   (in_cmd),
    .in_ready (cmd_ready),
    .rm_mask  (rm_mask),
    .slots    (slots),
    .slot_vld (slot_vld)
  );

  flash_dispatch_pick u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .slots     (slots),
    .slot_vld  (slot_vld),
    .chip_free (chip_free),
    .iss_ready (iss_ready),
    .iss_valid (iss_valid),
    .iss_idx   (iss_idx),
    .rm_mask   (rm_mask),
    .chip_take (chip_take)
  );

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_out
    assign iss_op[b]    = slots[iss_idx[b]].op;
    assign iss_chip[b]  = slots[iss_idx[b]].chip;
    assign iss_block[b] = slots[iss_idx[b]].block;
    assign iss_page[b]  = slots[iss_idx[b]].page;
    assign iss_tag[b]   = slots[iss_idx[b]].tag;
  end

  flash_chip_locks u_locks (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_take  (chip_take),
    .bus_tag    (iss_tag),
    .done_pulse (done_pulse),
    .cpl_ready  (cpl_ready),
    .chip_free  (chip_free),
    .cpl_valid  (cpl_valid),
    .cpl_tag    (cpl_tag)
  );
endmodule

// File: tb/test_flash_cmd_sched.sv
`timescale 1ns/1ps
module test_flash_cmd_sched;
  import flash_sched_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                            cmd_valid = 1'b0;
  logic                            cmd_ready;
  logic [1:0]                      cmd_op = '0;
  logic [BUS_W-1:0]                cmd_bus = '0;
  logic [CHIP_W-1:0]               cmd_chip = '0;
  logic [BLOCK_W-1:0]              cmd_block = '0;
  logic [PAGE_W-1:0]               cmd_page = '0;
  logic [TAG_W-1:0]                cmd_tag = '0;
  logic [NUM_BUS-1:0]              iss_valid;
  logic [NUM_BUS-1:0]              iss_ready = '0;
  logic [NUM_BUS-1:0][1:0]         iss_op;
  logic [NUM_BUS-1:0][CHIP_W-1:0]  iss_chip;
  logic [NUM_BUS-1:0][BLOCK_W-1:0] iss_block;
  logic [NUM_BUS-1:0][PAGE_W-1:0]  iss_page;
  logic [NUM_BUS-1:0][TAG_W-1:0]   iss_tag;
  logic [NCHIP-1:0]                done_pulse = '0;
  logic                            cpl_valid;
  logic                            cpl_ready = 1'b0;
  logic [TAG_W-1:0]                cpl_tag;

  flash_cmd_sched i_flash_cmd_sched (.*);

  int    nvec = 0;
  int    nbad = 0;
  string phase = "R1";

  // Behavioural reference: ordered list of commands and chip states
  // (0 free, 1 in flight, 2 finished awaiting report).
  typedef struct { int op; int bus; int chip; int blk; int pg; int tag; } mcmd_t;
  mcmd_t mq[$];
  int    mst[NCHIP];
  int    mtag[NCHIP];
  bit    mhold = 1'b0;
  int    mhidx = 0;
  bit    e_iv[NUM_BUS];
  int    e_ix[NUM_BUS];
  bit    e_cv;
  int    e_cs;
  bit    e_rdy;

  function automatic int cid_of(mcmd_t c);
    return c.bus * CHIPS_PER_BUS + c.chip;
  endfunction

  function automatic bit may_go(int i);
    if (mst[cid_of(mq[i])] != 0) return 1'b0;
    for (int k = 0; k < i; k++) begin
      if (mq[k].bus == mq[i].bus && mq[k].chip == mq[i].chip) begin
        if (mq[i].op != 0) return 1'b0;
        if (mq[k].op == 1 && mq[k].blk == mq[i].blk && mq[k].pg == mq[i].pg) return 1'b0;
        if (mq[k].op == 2 && mq[k].blk == mq[i].blk) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  function automatic void m_eval();
    e_rdy = (mq.size() < QDEPTH);
    for (int b = 0; b < NUM_BUS; b++) begin
      e_iv[b] = 1'b0;
      e_ix[b] = 0;
      for (int pass = 0; pass < 2; pass++)
        for (int i = 0; i < mq.size(); i++)
          if (!e_iv[b] && mq[i].bus == b && ((pass == 0) == (mq[i].op == 0)) && may_go(i)) begin
            e_iv[b] = 1'b1;
            e_ix[b] = i;
          end
    end
    e_cv = 1'b0;
    e_cs = 0;
    if (mhold) begin
      e_cv = 1'b1;
      e_cs = mhidx;
    end else begin
      for (int c = NCHIP - 1; c >= 0; c--)
        if (mst[c] == 2) begin
          e_cv = 1'b1;
          e_cs = c;
        end
    end
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(int'(cmd_ready) == int'(e_rdy), phase, "cmd_ready", int'(cmd_ready), int'(e_rdy));
    for (int b = 0; b < NUM_BUS; b++) begin
      chk(int'(iss_valid[b]) == int'(e_iv[b]), phase, "iss_valid", int'(iss_valid[b]), int'(e_iv[b]));
      if (e_iv[b] && iss_valid[b]) begin
        chk(int'(iss_op[b]) == mq[e_ix[b]].op, phase, "iss_op", int'(iss_op[b]), mq[e_ix[b]].op);
        chk(int'(iss_chip[b]) == mq[e_ix[b]].chip, phase, "iss_chip", int'(iss_chip[b]), mq[e_ix[b]].chip);
        chk(int'(iss_block[b]) == mq[e_ix[b]].blk, phase, "iss_block", int'(iss_block[b]), mq[e_ix[b]].blk);
        if (mq[e_ix[b]].op != 2)
          chk(int'(iss_page[b]) == mq[e_ix[b]].pg, phase, "iss_page", int'(iss_page[b]), mq[e_ix[b]].pg);
        chk(int'(iss_tag[b]) == mq[e_ix[b]].tag, phase, "iss_tag", int'(iss_tag[b]), mq[e_ix[b]].tag);
      end
    end
    chk(int'(cpl_valid) == int'(e_cv), phase, "cpl_valid", int'(cpl_valid), int'(e_cv));
    if (e_cv && cpl_valid)
      chk(int'(cpl_tag) == mtag[e_cs], phase, "cpl_tag", int'(cpl_tag), mtag[e_cs]);
  endtask

  task automatic m_update();
    bit del[QDEPTH];
    mcmd_t n;
    for (int i = 0; i < QDEPTH; i++) del[i] = 1'b0;
    for (int c = 0; c < NCHIP; c++)
      if (done_pulse[c] && mst[c] == 1) mst[c] = 2;
    if (e_cv && cpl_ready) mst[e_cs] = 0;
    mhold = e_cv && !cpl_ready;
    mhidx = e_cs;
    for (int b = 0; b < NUM_BUS; b++)
      if (e_iv[b] && iss_ready[b]) begin
        mst[cid_of(mq[e_ix[b]])]  = 1;
        mtag[cid_of(mq[e_ix[b]])] = mq[e_ix[b]].tag;
        del[e_ix[b]] = 1'b1;
      end
    for (int i = QDEPTH - 1; i >= 0; i--)
      if (del[i]) mq.delete(i);
    if (cmd_valid && e_rdy) begin
      n.op = int'(cmd_op); n.bus = int'(cmd_bus); n.chip = int'(cmd_chip);
      n.blk = int'(cmd_block); n.pg = int'(cmd_page); n.tag = int'(cmd_tag);
      mq.push_back(n);
    end
  endtask

  task automatic step();
    @(posedge clk);
    m_update();
    @(negedge clk);
    m_eval();
    compare();
  endtask

  task automatic send(int op, int bus, int chip, int blk, int pg, int tag);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_bus   = BUS_W'(bus);
    cmd_chip  = CHIP_W'(chip);
    cmd_block = BLOCK_W'(blk);
    cmd_page  = PAGE_W'(pg);
    cmd_tag   = TAG_W'(tag);
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic rand_run(int n, bit one_chip);
    for (int t = 0; t < n; t++) begin
      cmd_valid = (($urandom % 10) < 6);
      cmd_op    = 2'($urandom % 3);
      cmd_bus   = BUS_W'($urandom % NUM_BUS);
      cmd_chip  = one_chip ? '0 : CHIP_W'($urandom % 4);
      cmd_block = BLOCK_W'($urandom % 3);
      cmd_page  = PAGE_W'($urandom % 3);
      cmd_tag   = TAG_W'($urandom % 16);
      for (int b = 0; b < NUM_BUS; b++) iss_ready[b] = (($urandom % 4) != 0);
      cpl_ready = (($urandom % 10) < 7);
      done_pulse = '0;
      for (int c = 0; c < NCHIP; c++)
        if (mst[c] == 1 && ($urandom % 4) == 0) done_pulse[c] = 1'b1;
      step();
    end
    cmd_valid  = 1'b0;
    done_pulse = '0;
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCHIP; c++) begin mst[c] = 0; mtag[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_eval();
    compare();
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
    chk(iss_valid == '0, "R1", "iss_valid", int'(iss_valid), 0);
    chk(cpl_valid == 1'b0, "R1", "cpl_valid", int'(cpl_valid), 0);

    phase = "R3";
    send(1, 0, 1, 5, 2, 1);
    send(0, 0, 1, 5, 3, 2);
    send(1, 1, 2, 7, 1, 4);
    send(0, 1, 2, 7, 1, 5);
    send(2, 2, 3, 9, 0, 6);
    send(0, 2, 3, 9, 5, 7);
    chk(int'(iss_op[0]) == 0 && int'(iss_tag[0]) == 2, "R3", "bus0 bypass read tag",
        int'(iss_tag[0]), 2);
    chk(int'(iss_op[1]) == 1 && int'(iss_tag[1]) == 4, "R4", "bus1 program before dependent read",
        int'(iss_tag[1]), 4);
    chk(int'(iss_op[2]) == 2 && int'(iss_tag[2]) == 6, "R4", "bus2 erase before dependent read",
        int'(iss_tag[2]), 6);

    phase = "R9";
    iss_ready = '1;
    chk(iss_valid == 4'b0111, "R9", "three buses offering", int'(iss_valid), 7);
    step();
    iss_ready = '0;
    chk(iss_valid == '0, "R2", "locked chips offer nothing", int'(iss_valid), 0);

    phase = "R10";
    done_pulse[18] = 1'b1;
    step();
    done_pulse = '0;
    chk(cpl_valid && int'(cpl_tag) == 4, "R7", "completion tag", int'(cpl_tag), 4);
    done_pulse[1] = 1'b1;
    step();
    done_pulse = '0;
    chk(cpl_valid && int'(cpl_tag) == 4, "R10", "held completion tag", int'(cpl_tag), 4);

    phase = "R7";
    cpl_ready = 1'b1;
    step();
    cpl_ready = 1'b0;
    chk(cpl_valid && int'(cpl_tag) == 2, "R7", "next completion tag", int'(cpl_tag), 2);
    chk(iss_valid[1] && int'(iss_tag[1]) == 5, "R7", "bus1 reissue after release",
        int'(iss_tag[1]), 5);
    cpl_ready = 1'b1;
    step();
    cpl_ready = 1'b0;
    chk(iss_valid[0] && int'(iss_op[0]) == 1 && int'(iss_tag[0]) == 1, "R7",
        "bus0 program after release", int'(iss_tag[0]), 1);

    phase = "R8";
    for (int i = 0; i < 5; i++) send(1, 3, i, 1, 0, 8 + i);
    chk(cmd_ready == 1'b0, "R8", "ready low when full", int'(cmd_ready), 0);
    send(0, 3, 5, 1, 0, 13);
    chk(cmd_ready == 1'b0, "R8", "ready still low", int'(cmd_ready), 0);

    phase = "R5";
    rand_run(3000, 1'b1);
    phase = "R6";
    rand_run(6000, 1'b0);
    phase = "R4";
    rand_run(3000, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule